// File: doc/BRIEF.md
# Reference Clock Request Controller

This block decides whether a shared reference clock is needed by a group of serial storage ports and tells an external clock generator so through a single open-drain, active-low pad. The pad is pulled low to ask for the clock and let go (high impedance) to say the clock may be stopped. The data value presented to the pad is always zero, so the pin is never driven high.

Each port reports its link power state. The block synchronises these states into an always-on clock domain. It lets go of the pad only when every port sits in its deepest sleep state or is switched off, and only after that condition has held for a programmable number of cycles. Release also requires a configuration enable bit and requires the shared pad to be muxed to its native function. When a port wakes, or the enable bit is cleared, the request is taken back at once. Because the generator may stop the clock at any moment after release, or never stop it, the block assumes nothing about the clock's state. After every reassertion it counts a settle interval before it raises the clock-valid indication that ports wait on before leaving sleep.

Top module: `refclk_req_ctrl`

## Requirements
- R1: The pad data output `padOut` is 0 at all times; the pin is controlled only through `padOe`, where 1 pulls the pin low (request) and 0 releases it.
- R2: Each port's link state is a 2-bit field at bits [2p+1:2p] of `linkState`, encoded 0 = active, 1 = partial (shallow sleep), 2 = slumber, 3 = disabled. The request is released only while every port reads 2 or 3. A single port reading 0 or 1 keeps the request asserted.
- R3: While reset is held and after its release, the request is asserted (`padOe` = 1 with the pad in native mode) and `clkValid` is 0.
- R4: With `reqEnable` = 0 the request stays asserted permanently. Clearing `reqEnable` while released reasserts the request at the next clock edge, and `clkValid` then rises `SETTLE_CYCLES` edges after that edge.
- R5: With `padNative` = 0 the block leaves the pad alone (`padOe` = 0) and never enters the released state.
- R6: `clkValid` is 0 whenever the request is released. After every reassertion (including reset) it rises exactly `SETTLE_CYCLES` clock edges after the edge at which the request was asserted.
- R7: A port leaving the idle states while the request is released reasserts the request on the third clock edge after the input change: two synchroniser edges, then one more edge.
- R8: Release happens only from the clock-valid state, after the all-idle condition has held for `HOLDOFF_CYCLES` consecutive cycles. With synchroniser latency, this is on edge 2 + `HOLDOFF_CYCLES` after the inputs become idle. An idle spell shorter than `HOLDOFF_CYCLES` cycles causes no release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkState | input | 2*NUM_PORTS | Per-port link power state, 2 bits per port |
| reqEnable | input | 1 | Configuration enable for releasing the request |
| padNative | input | 1 | 1 = pad muxed to native clock-request function |
| padOe | output | 1 | Pad output enable; 1 pulls the pin low |
| padOut | output | 1 | Pad data value, constant 0 |
| clkValid | output | 1 | Reference clock is known to be running and settled |

## Verification
The bench builds the block with three ports, a hold-off of 4 cycles and a settle count of 5 cycles. These short windows bring the exact release edge, the exact clock-valid rise edge, and the one-cycle-short idle glitch within reach of edge-accurate checks. Three ports are enough to mix active, partial, slumber and disabled states in one vector.

// File: rtl/refclk_req_pkg.sv
package refclk_req_pkg;

  typedef enum logic [1:0] {
    LINK_ACTIVE  = 2'd0,
    LINK_PARTIAL = 2'd1,
    LINK_SLUMBER = 2'd2,
    LINK_OFF     = 2'd3
  } linkState_e;

  typedef enum logic [1:0] {
    ST_SETTLE   = 2'd0,
    ST_VALID    = 2'd1,
    ST_RELEASED = 2'd2
  } reqState_e;

  typedef struct packed {
    logic holdClr;
    logic holdInc;
    logic settleClr;
    logic settleInc;
  } ctrlStrobe_t;

endpackage

// File: rtl/refclk_req_sync.sv
module refclk_req_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= dIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/refclk_req_dp.sv
module refclk_req_dp
  import refclk_req_pkg::*;
#(
  parameter int NUM_PORTS      = 4,
  parameter int HOLDOFF_CYCLES = 64,
  parameter int SETTLE_CYCLES  = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*NUM_PORTS-1:0] linkSync,
  input  ctrlStrobe_t            strobe,
  output logic                   allIdle,
  output logic                   holdLast,
  output logic                   settleLast
);
  localparam int HOLD_W   = $clog2(HOLDOFF_CYCLES + 1);
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);

  logic [NUM_PORTS-1:0] portIdle;
  logic [HOLD_W-1:0]    holdCnt;
  logic [SETTLE_W-1:0]  settleCnt;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    linkState_e ls;
    assign ls          = linkState_e'(linkSync[2*p +: 2]);
    assign portIdle[p] = (ls == LINK_SLUMBER) || (ls == LINK_OFF);
  end

  assign allIdle = &portIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (strobe.holdClr) holdCnt <= '0;
    else if (strobe.holdInc) holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 settleCnt <= '0;
    else if (strobe.settleClr) settleCnt <= '0;
    else if (strobe.settleInc) settleCnt <= settleCnt + 1'b1;
  end

  assign holdLast   = (holdCnt == HOLD_W'(HOLDOFF_CYCLES - 1));
  assign settleLast = (settleCnt == SETTLE_W'(SETTLE_CYCLES - 1));
endmodule

// File: rtl/refclk_req_fsm.sv
module refclk_req_fsm
  import refclk_req_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        allIdle,
  input  logic        reqEnable,
  input  logic        padNative,
  input  logic        holdLast,
  input  logic        settleLast,
  output ctrlStrobe_t strobe,
  output logic        reqActive,
  output logic        clkValid
);
  reqState_e state, stateNext;
  logic      canIdle;

  assign canIdle = allIdle && reqEnable && padNative;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_SETTLE: begin
        strobe.settleInc = 1'b1;
        strobe.holdClr   = 1'b1;
        if (settleLast) begin
          stateNext        = ST_VALID;
          strobe.settleClr = 1'b1;
        end
      end
      ST_VALID: begin
        strobe.settleClr = 1'b1;
        if (!canIdle) begin
          strobe.holdClr = 1'b1;
        end else if (holdLast) begin
          strobe.holdClr = 1'b1;
          stateNext      = ST_RELEASED;
        end else begin
          strobe.holdInc = 1'b1;
        end
      end
      ST_RELEASED: begin
        strobe.settleClr = 1'b1;
        strobe.holdClr   = 1'b1;
        if (!canIdle) stateNext = ST_SETTLE;
      end
      default: stateNext = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SETTLE;
    else       state <= stateNext;
  end

  assign reqActive = (state != ST_RELEASED);
  assign clkValid  = (state == ST_VALID);
endmodule

// File: rtl/refclk_req_ctrl.sv
module refclk_req_ctrl
  import refclk_req_pkg::*;
#(
  parameter int NUM_PORTS      = 4,
  parameter int HOLDOFF_CYCLES = 64,
  parameter int SETTLE_CYCLES  = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*NUM_PORTS-1:0] linkState,
  input  logic                   reqEnable,
  input  logic                   padNative,
  output logic                   padOe,
  output logic                   padOut,
  output logic                   clkValid
);
  localparam int LS_W = 2 * NUM_PORTS;

  logic [LS_W-1:0] linkSync;
  ctrlStrobe_t     strobe;
  logic            allIdle, holdLast, settleLast, reqActive;

  refclk_req_sync #(.WIDTH(LS_W), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .dIn(linkState), .dOut(linkSync)
  );

  refclk_req_dp #(
    .NUM_PORTS(NUM_PORTS), .HOLDOFF_CYCLES(HOLDOFF_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .linkSync(linkSync), .strobe(strobe),
    .allIdle(allIdle), .holdLast(holdLast), .settleLast(settleLast)
  );

  refclk_req_fsm u_fsm (
    .clk(clk), .rstN(rstN), .allIdle(allIdle), .reqEnable(reqEnable),
    .padNative(padNative), .holdLast(holdLast), .settleLast(settleLast),
    .strobe(strobe), .reqActive(reqActive), .clkValid(clkValid)
  );

  // R1: open-drain pad, data tied low, only the enable moves
  assign padOut = 1'b0;
  assign padOe  = padNative && reqActive;
endmodule

// File: rtl/refclk_req_checker.sv
module refclk_req_checker (
  input logic clk,
  input logic rstN,
  input logic reqEnable,
  input logic padNative,
  input logic padOe,
  input logic clkValid,
  input logic reqActive
);
  p_gpio_hands_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !padNative |-> !padOe);

  p_valid_needs_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    clkValid |-> reqActive);

  p_off_keeps_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    !reqEnable |=> reqActive);

  p_release_needs_cfg_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqActive) |-> ($past(reqEnable) && $past(padNative)));

  p_release_from_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqActive) |-> $past(clkValid));

  p_valid_rise_after_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkValid) |-> $past(reqActive));
endmodule

bind refclk_req_ctrl refclk_req_checker u_chk (
  .clk(clk), .rstN(rstN), .reqEnable(reqEnable), .padNative(padNative),
  .padOe(padOe), .clkValid(clkValid), .reqActive(reqActive)
);

// File: tb/refclk_req_ctrl_tb.sv
`timescale 1ns/1ps
module refclk_req_ctrl_tb;
  localparam int NP = 3;
  localparam int HO = 4;
  localparam int ST = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2*NP-1:0] linkState = '0;
  logic reqEnable = 1'b1;
  logic padNative = 1'b1;
  logic padOe, padOut, clkValid;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  refclk_req_ctrl #(.NUM_PORTS(NP), .HOLDOFF_CYCLES(HO), .SETTLE_CYCLES(ST)) u_dut (
    .clk(clk), .rstN(rstN), .linkState(linkState), .reqEnable(reqEnable),
    .padNative(padNative), .padOe(padOe), .padOut(padOut), .clkValid(clkValid)
  );

  // fields: [9:4] link states, [3] enable, [2] native, [1] expected oe, [0] expected valid
  localparam logic [9:0] VEC [8] = '{
    {6'b101010, 1'b1, 1'b1, 1'b0, 1'b0},  // R2 all slumber -> released
    {6'b101000, 1'b1, 1'b1, 1'b1, 1'b1},  // R2 one active -> held
    {6'b111111, 1'b1, 1'b1, 1'b0, 1'b0},  // R2 all disabled -> released
    {6'b011111, 1'b1, 1'b1, 1'b1, 1'b1},  // R2 one partial -> held
    {6'b101010, 1'b0, 1'b1, 1'b1, 1'b1},  // R4 enable clear -> held
    {6'b101010, 1'b1, 1'b0, 1'b0, 1'b1},  // R5 gpio mode -> hands off
    {6'b101110, 1'b1, 1'b1, 1'b0, 1'b0},  // R2 slumber/disabled mix
    {6'b000000, 1'b1, 1'b1, 1'b1, 1'b1}   // R2 all active
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3 reset state
    linkState = '0;
    tick(3);
    check("R3", padOe, 1'b1, "oe in reset");
    check("R3", clkValid, 1'b0, "valid in reset");
    check("R1", padOut, 1'b0, "pad data in reset");
    rstN = 1'b1;
    // R6 valid rises exactly ST edges after reset release
    tick(ST - 1);
    check("R6", clkValid, 1'b0, "valid one edge early");
    check("R3", padOe, 1'b1, "oe after reset");
    tick(1);
    check("R6", clkValid, 1'b1, "valid at settle end");

    // steady-state table walk
    for (int i = 0; i < 8; i++) begin
      linkState = VEC[i][9:4];
      reqEnable = VEC[i][3];
      padNative = VEC[i][2];
      tick(20);
      check("R2", padOe, VEC[i][1], $sformatf("vector %0d oe", i));
      check("R6", clkValid, VEC[i][0], $sformatf("vector %0d valid", i));
      check("R1", padOut, 1'b0, $sformatf("vector %0d pad data", i));
    end

    // R8 exact hold-off edge
    linkState = 6'b101010;
    tick(1 + HO);
    check("R8", padOe, 1'b1, "still held one edge before holdoff");
    tick(1);
    check("R8", padOe, 1'b0, "released at holdoff");
    check("R6", clkValid, 1'b0, "valid low when released");

    // R7 wake timing and R6 settle after wake
    linkState = 6'b100010;
    tick(2);
    check("R7", padOe, 1'b0, "not yet reasserted after sync");
    tick(1);
    check("R7", padOe, 1'b1, "reasserted on third edge");
    tick(ST - 1);
    check("R6", clkValid, 1'b0, "valid one edge before settle");
    tick(1);
    check("R6", clkValid, 1'b1, "valid after settle");

    // R8 short idle spell causes no release
    linkState = 6'b101010;
    tick(HO - 1);
    linkState = 6'b000000;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      check("R8", padOe, 1'b1, "short idle no release");
    end

    // R4 enable clear while released
    linkState = 6'b111010;
    tick(20);
    check("R4", padOe, 1'b0, "released before enable clear");
    reqEnable = 1'b0;
    tick(1);
    check("R4", padOe, 1'b1, "reassert next edge");
    check("R4", clkValid, 1'b0, "valid low after reassert");
    tick(ST - 1);
    check("R4", clkValid, 1'b0, "valid one edge early");
    tick(1);
    check("R4", clkValid, 1'b1, "valid after restart settle");

    // R5 gpio mode while idle: pad untouched, no release
    reqEnable = 1'b1;
    padNative = 1'b0;
    tick(20);
    check("R5", padOe, 1'b0, "gpio oe");
    check("R5", clkValid, 1'b1, "gpio keeps internal request");
    padNative = 1'b1;
    tick(1);
    check("R5", padOe, 1'b1, "native resumes request");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule